// File: doc/BRIEF.md
# Resource Descriptor Stream Parser

This block takes a byte stream of plug-and-play resource descriptors over a valid/ready handshake and divides it into items. Each item opens with a header byte. The top bit of that header picks one of two formats. A small item carries its name and a three-bit payload length in the header itself. A large item carries a seven-bit name, and the header is followed by a sixteen-bit payload length sent low byte first. The parser does not interpret payload bytes. It only counts them, so that it knows where the next header starts.

For every item the parser reports:
- whether the item is small or large,
- the item name,
- the payload length,
- a one-cycle pulse when the header is accepted,
- a one-cycle pulse when the last byte of the item is accepted.

A name from a reserved range sets a sticky warning. Such an item is still skipped using its length. The small end-tag item closes the stream: once its payload has been consumed, the parser raises `done` and refuses further bytes until reset.

Top module: `rsrc_item_parser`

## Requirements
- R1: A header byte with bit 7 = 0 is a small item. The name is bits [6:3], zero-extended on `item_name`, and the length is bits [2:0]. In the cycle after the header is accepted, `item_start` pulses, `item_large` = 0, and `item_name` and `item_len` show those fields.
- R2: A header byte with bit 7 = 1 is a large item. The name is bits [6:0]. `item_start` pulses and `item_large` = 1 in the cycle after the header is accepted. The next two accepted bytes are the payload length, low byte first, and `item_len` shows that length in the cycle after the high byte is accepted.
- R3: `item_end` pulses for exactly one cycle, in the cycle after the last payload byte of an item is accepted. Only beats with `in_valid` and `in_ready` both high count as payload bytes.
- R4: A zero-length item ends with its final header byte. For a small item that is the header itself, so `item_start` and `item_end` pulse in the same cycle. For a large item it is the high length byte.
- R5: Reserved names set `rsvd_warn`. These are small names 0xA to 0xD, large name 0x00, and large names 0x07 to 0x7F. The flag becomes visible in the cycle after the header is accepted, stays set until reset, and the item is still skipped by its length so the next header is decoded.
- R6: Small name 0xF is the end tag. In the cycle after its last byte is accepted, `done` rises and `in_ready` falls. Both hold until reset, and no further item starts.
- R7: While and after reset with no input, `in_ready` = 1, and `done`, `rsvd_warn`, `item_start` and `item_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte is valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| item_start | output | 1 | Pulse: header of an item accepted |
| item_end | output | 1 | Pulse: last byte of an item accepted |
| item_large | output | 1 | Current item is a large item |
| item_name | output | 7 | Current item name |
| item_len | output | 16 | Current item payload length |
| rsvd_warn | output | 1 | Sticky: a reserved name was seen |
| done | output | 1 | End tag fully consumed |

## Verification
Every result is registered and is due one cycle after the byte that causes it is accepted. `item_start`, `item_name`, `item_large` and `rsvd_warn` follow the header. `item_len` of a large item follows its high length byte. `item_end` and `done` follow the final byte of the item. The bench drives each byte on a falling edge, lets one rising edge accept it, and samples the outputs on the next falling edge, so each check lands in the cycle where its result is due. Stalled cycles with `in_valid` low are inserted mid-payload, and the bench checks that they do not move the end pulse.

// File: rtl/rip_pkg.sv
package rip_pkg;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_LEN_LO = 3'd1,
    ST_LEN_HI = 3'd2,
    ST_BODY   = 3'd3,
    ST_HALT   = 3'd4
  } pstate_t;

  localparam logic [3:0] SMALL_END_NAME = 4'hF;

  function automatic logic small_name_reserved(input logic [3:0] nm);
    return (nm >= 4'hA) && (nm <= 4'hD);
  endfunction

  function automatic logic large_name_reserved(input logic [6:0] nm);
    return (nm == 7'h00) || (nm >= 7'h07);
  endfunction

endpackage

// File: rtl/rip_hdr_decode.sv
module rip_hdr_decode #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] hdr,
  output logic              is_large,
  output logic [BYTE_W-2:0] name,
  output logic [2:0]        short_len,
  output logic              is_end_tag,
  output logic              is_rsvd
);
  import rip_pkg::*;

  localparam int NAME_W = BYTE_W - 1;

  logic [3:0] small_nm;

  always_comb begin
    is_large  = hdr[BYTE_W-1];
    small_nm  = hdr[6:3];
    short_len = hdr[2:0];
    if (is_large) begin
      name       = hdr[NAME_W-1:0];
      is_end_tag = 1'b0;
      is_rsvd    = large_name_reserved(hdr[6:0]);
    end else begin
      name       = '0;
      name[3:0]  = small_nm;
      is_end_tag = (small_nm == SMALL_END_NAME);
      is_rsvd    = small_name_reserved(small_nm);
    end
  end

endmodule

// File: rtl/rip_len_counter.sv
module rip_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] remaining,
  output logic             last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (dec && remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign last = (remaining == {{(LEN_W-1){1'b0}}, 1'b1});

  // R3
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> remaining != '0);

endmodule

// File: rtl/rsrc_item_parser.sv
module rsrc_item_parser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              item_start,
  output logic              item_end,
  output logic              item_large,
  output logic [BYTE_W-2:0] item_name,
  output logic [2*BYTE_W-1:0] item_len,
  output logic              rsvd_warn,
  output logic              done
);
  import rip_pkg::*;

  localparam int NAME_W = BYTE_W - 1;
  localparam int LEN_W  = 2 * BYTE_W;

  pstate_t st;
  logic [BYTE_W-1:0] len_lo;
  logic              cur_is_end;
  logic              accept;

  logic              d_large;
  logic [NAME_W-1:0] d_name;
  logic [2:0]        d_slen;
  logic              d_end;
  logic              d_rsvd;

  logic              cnt_load;
  logic [LEN_W-1:0]  cnt_val;
  logic              cnt_dec;
  logic [LEN_W-1:0]  cnt_rem;
  logic              cnt_last;
  logic [LEN_W-1:0]  full_len;

  assign in_ready = (st != ST_HALT);
  assign accept   = in_valid && in_ready;
  assign full_len = {in_byte, len_lo};

  rip_hdr_decode #(.BYTE_W(BYTE_W)) u_dec (
    .hdr        (in_byte),
    .is_large   (d_large),
    .name       (d_name),
    .short_len  (d_slen),
    .is_end_tag (d_end),
    .is_rsvd    (d_rsvd)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept && st == ST_HDR && !d_large) begin
      cnt_load = 1'b1;
      cnt_val  = {{(LEN_W-3){1'b0}}, d_slen};
    end else if (accept && st == ST_LEN_HI) begin
      cnt_load = 1'b1;
      cnt_val  = full_len;
    end
  end

  assign cnt_dec = accept && (st == ST_BODY);

  rip_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (cnt_load),
    .load_val  (cnt_val),
    .dec       (cnt_dec),
    .remaining (cnt_rem),
    .last      (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HDR;
      len_lo     <= '0;
      cur_is_end <= 1'b0;
      item_start <= 1'b0;
      item_end   <= 1'b0;
      item_large <= 1'b0;
      item_name  <= '0;
      item_len   <= '0;
      rsvd_warn  <= 1'b0;
      done       <= 1'b0;
    end else begin
      item_start <= 1'b0;
      item_end   <= 1'b0;
      if (accept) begin
        case (st)
          ST_HDR: begin
            item_start <= 1'b1;
            item_large <= d_large;
            item_name  <= d_name;
            cur_is_end <= d_end;
            if (d_rsvd) rsvd_warn <= 1'b1;
            if (d_large) begin
              item_len <= '0;
              st       <= ST_LEN_LO;
            end else begin
              item_len <= {{(LEN_W-3){1'b0}}, d_slen};
              if (d_slen == 3'd0) begin
                item_end <= 1'b1;
                if (d_end) begin
                  done <= 1'b1;
                  st   <= ST_HALT;
                end
              end else begin
                st <= ST_BODY;
              end
            end
          end
          ST_LEN_LO: begin
            len_lo <= in_byte;
            st     <= ST_LEN_HI;
          end
          ST_LEN_HI: begin
            item_len <= full_len;
            if (full_len == '0) begin
              item_end <= 1'b1;
              st       <= ST_HDR;
            end else begin
              st <= ST_BODY;
            end
          end
          ST_BODY: begin
            if (cnt_last) begin
              item_end <= 1'b1;
              if (cur_is_end) begin
                done <= 1'b1;
                st   <= ST_HALT;
              end else begin
                st <= ST_HDR;
              end
            end
          end
          default: st <= ST_HALT;
        endcase
      end
    end
  end

  // R1
  start_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    item_start |-> $past(in_valid && in_ready));

  // R3
  end_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    item_end |-> $past(in_valid && in_ready));

  // R5
  warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_warn |=> rsvd_warn);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !in_ready);

  // R6
  no_start_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> !item_start);

endmodule

// File: tb/rsrc_item_parser_test.sv
module rsrc_item_parser_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        item_start;
  logic        item_end;
  logic        item_large;
  logic [6:0]  item_name;
  logic [15:0] item_len;
  logic        rsvd_warn;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsrc_item_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .item_start(item_start), .item_end(item_end),
    .item_large(item_large), .item_name(item_name), .item_len(item_len),
    .rsvd_warn(rsvd_warn), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // drive one byte, let one rising edge take it, sample at the next falling edge
  task automatic push(input logic [7:0] b, output logic s, output logic e);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
    s = item_start;
    e = item_end;
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_byte  = 8'h00;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chkv("R7 in_ready", in_ready, 1);
    chkv("R7 done", done, 0);
    chkv("R7 rsvd_warn", rsvd_warn, 0);
    chkv("R7 item_start", item_start, 0);
    chkv("R7 item_end", item_end, 0);
  endtask

  task automatic t_small_item();
    logic s, e;
    // header 0x13: small, name 2, length 3
    push(8'h13, s, e);
    chkv("R1 start", s, 1);
    chkv("R1 large", item_large, 0);
    chkv("R1 name", item_name, 2);
    chkv("R1 len", item_len, 3);
    chkv("R3 no end at header", e, 0);
    for (int i = 0; i < 3; i++) begin
      push(8'hC0 + 8'(i), s, e);
      chkv("R3 end on last payload", e, (i == 2) ? 1 : 0);
      chkv("R1 no start in payload", s, 0);
    end
    @(negedge clk);
    chkv("R3 end single cycle", item_end, 0);
  endtask

  task automatic t_small_zero();
    logic s, e;
    // header 0x30: small, name 6, length 0
    push(8'h30, s, e);
    chkv("R4 start", s, 1);
    chkv("R4 end same cycle", e, 1);
    chkv("R4 name", item_name, 6);
    chkv("R4 len", item_len, 0);
  endtask

  task automatic t_large_item();
    logic s, e;
    // large name 1, length 2
    push(8'h81, s, e);
    chkv("R2 start", s, 1);
    chkv("R2 large", item_large, 1);
    chkv("R2 name", item_name, 1);
    push(8'h02, s, e);
    chkv("R2 no end at len lo", e, 0);
    push(8'h00, s, e);
    chkv("R2 len", item_len, 2);
    chkv("R2 no end at len hi", e, 0);
    push(8'hAA, s, e);
    chkv("R3 no end early", e, 0);
    push(8'hBB, s, e);
    chkv("R3 end last", e, 1);
  endtask

  task automatic t_large_zero();
    logic s, e;
    push(8'h82, s, e);
    chkv("R2 start zero", s, 1);
    push(8'h00, s, e);
    chkv("R4 no end lo", e, 0);
    push(8'h00, s, e);
    chkv("R4 large end at len hi", e, 1);
    chkv("R4 large len", item_len, 0);
  endtask

  task automatic t_large_long_stall();
    logic s, e;
    int early = 0;
    // large name 6, length 0x0102 = 258, low byte first
    push(8'h86, s, e);
    push(8'h02, s, e);
    push(8'h01, s, e);
    chkv("R2 byte order len", item_len, 258);
    for (int i = 0; i < 258; i++) begin
      if (i == 100) begin
        in_byte = 8'hFF;
        repeat (3) begin
          @(negedge clk);
          if (item_end) early++;
        end
      end
      push(8'(i), s, e);
      if (i < 257 && e) early++;
      if (i == 257) chkv("R3 end after 258 bytes", e, 1);
    end
    chkv("R3 no early end with stalls", early, 0);
    chkv("R5 no warn on defined names", rsvd_warn, 0);
  endtask

  task automatic t_reserved();
    logic s, e;
    // small name 0xA length 1 : 0x51
    push(8'h51, s, e);
    chkv("R5 warn set", rsvd_warn, 1);
    push(8'h33, s, e);
    chkv("R5 reserved item skipped", e, 1);
    push(8'h10, s, e); // small name 2, length 0
    chkv("R5 next header start", s, 1);
    chkv("R5 next header name", item_name, 2);
    chkv("R5 warn sticky", rsvd_warn, 1);
  endtask

  task automatic t_end_tag();
    logic s, e;
    // end tag with one payload byte: 0x79
    push(8'h79, s, e);
    chkv("R6 not done at header", done, 0);
    push(8'h5A, s, e);
    chkv("R6 end pulse", e, 1);
    chkv("R6 done", done, 1);
    chkv("R6 ready low", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      push(8'h13, s, e);
      chkv("R6 no start after done", s, 0);
    end
    chkv("R6 still done", done, 1);
    chkv("R6 still not ready", in_ready, 0);
  endtask

  task automatic t_end_zero_and_large_rsvd();
    logic s, e;
    do_reset();
    chkv("R7 warn cleared", rsvd_warn, 0);
    chkv("R7 done cleared", done, 0);
    push(8'hFF, s, e); // large name 0x7F reserved
    chkv("R5 large reserved warn", rsvd_warn, 1);
    push(8'h00, s, e);
    push(8'h00, s, e);
    chkv("R5 large reserved skipped", e, 1);
    push(8'h78, s, e); // end tag, length 0
    chkv("R6 zero end tag done", done, 1);
    chkv("R4 zero end tag pulses", s & e, 1);
  endtask

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_byte = 8'h00;
    t_reset_state();
    t_small_item();
    t_small_zero();
    t_large_item();
    t_large_zero();
    t_large_long_stall();
    t_reserved();
    t_end_tag();
    t_end_zero_and_large_rsvd();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule